// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns the peripheral clock into the bit timing for an I2C master. A prescale counter divides the peripheral clock by a programmable amount to give an internal tick. A phase counter then splits each SCL period into a low half and a high half, each `10 + 4*SCGD` ticks long. The block drives a request to pull SCL low during the low half and releases it during the high half. It also gives a quarter-phase code and single-cycle strobes that mark where SDA may change and where SDA is sampled. The master's shift and sequencing logic consumes these outputs.

The high half does not start counting until the released SCL line is seen high through a synchronizer. Rise time, the synchronizer's latency and any clock stretching by a target therefore add to the period as measured delay, not as a fixed allowance. The divider configuration word is captured when the generator is enabled and held for the whole run. Dropping the enable releases SCL and clears every counter.

Top module: `scl_timing_gen`

## Requirements
- R1: While `en_i` is low, and in the first cycle after it falls, `scl_low_o`, `tick_o`, `sda_chg_o` and `sda_smp_o` are 0 and `phase_o` is 0. The counters are cleared, so after a re-enable the next period starts with a full low half.
- R2: While running, `tick_o` pulses for one clock every CDF+1 clocks. CDF is `div_cfg_i[CDF_W-1:0]`.
- R3: SCGD is `div_cfg_i[CDF_W+5:CDF_W]`, and the half period is H = 10 + 4*SCGD ticks. Each low half lasts exactly H*(CDF+1) clocks, including the first one, which starts in the clock after `en_i` is sampled high.
- R4: Once the synchronized SCL is high, the high half runs for H ticks. The nominal period is 20 + 8*SCGD ticks.
- R5: SCL is sensed through a SYNC_STAGES flop synchronizer. Every tick at the start of the high half on which the synchronized SCL is still low is added to the high half. This lengthens the period by the real rise latency and by any time a target holds SCL low.
- R6: `sda_chg_o` pulses for one clock on low-half tick number M = 5 + 2*SCGD (counting from 0), i.e. in clock M*(CDF+1)+CDF of the low half.
- R7: `sda_smp_o` pulses for one clock on high-half counted tick number M. That is clock (M+W)*(CDF+1)+CDF of the high half, where W is the number of added wait ticks.
- R8: `phase_o` is 0 in the first M ticks of the low half and 1 in the rest of the low half. It is 2 from the start of the high half (wait ticks included) up to counted tick M, and 3 after that.
- R9: CDF and SCGD are captured in the clock where `en_i` is first seen high. Changes to `div_cfg_i` while enabled have no effect until the next enable.
- R10: `scl_low_o` is 1 exactly during the low half while running and 0 during the high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; a rising level captures the configuration |
| div_cfg_i | input | CDF_W+6 | Divider word: CDF in the low CDF_W bits, SCGD in the 6 bits above |
| scl_i | input | 1 | Sensed level of the SCL line |
| tick_o | output | 1 | Internal tick enable |
| scl_low_o | output | 1 | Request to pull SCL low |
| phase_o | output | 2 | Quarter of the SCL period |
| sda_chg_o | output | 1 | Strobe: SDA may change |
| sda_smp_o | output | 1 | Strobe: sample SDA |

## Verification
The bench sweeps every CDF value of a 2-bit prescale field against SCGD values from the minimum to the maximum, with SCL looped back from the pull-low request. Each sweep point shows whether the low length, tick spacing, strobe positions and quarter boundaries scale with the prescaler or with the period field. A loopback with no added delay checks the synchronizer wait arithmetic, which differs for CDF 0, 1 and 2 or more. A target holding SCL low for several clocks separates a generator that waits for SCL from one that counts a fixed high time. Changing the configuration mid-run and disabling mid-period show that the captured values and the counter clearing behave as required.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  localparam int unsigned SCGD_W = 6;
  localparam int unsigned HALF_W = SCGD_W + 3;

  typedef enum logic {
    SEG_LOW  = 1'b0,
    SEG_HIGH = 1'b1
  } seg_e;

  function automatic logic [HALF_W-1:0] half_ticks(input logic [SCGD_W-1:0] scgd);
    return HALF_W'(10) + HALF_W'({scgd, 2'b00});
  endfunction
endpackage

// File: rtl/scl_tg_prescale.sv
module scl_tg_prescale #(
  parameter int unsigned CDF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CDF_W-1:0] cdf_i,
  output logic             tick_o
);
  logic [CDF_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == cdf_i);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || wrap)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + CDF_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (cdf_i != '0) |=> !tick_o); // R2
  AST_PRE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= cdf_i); // R2
endmodule

// File: rtl/scl_tg_sync.sv
module scl_tg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] ff_q;

  // idle line reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[N-2:0], d_i};
  end

  assign q_o = ff_q[N-1];
endmodule

// File: rtl/scl_tg_phase.sv
module scl_tg_phase
  import scl_tg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [SCGD_W-1:0] scgd_i,
  input  logic              scl_s_i,
  output logic              scl_low_o,
  output logic [1:0]        phase_o,
  output logic              sda_chg_o,
  output logic              sda_smp_o
);
  seg_e              seg_q;
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] mid;
  logic              last;
  logic              waiting;

  assign half    = half_ticks(scgd_i);
  assign mid     = half >> 1;
  assign last    = (cnt_q == half - HALF_W'(1));
  // high count held at zero until released line is seen high
  assign waiting = (seg_q == SEG_HIGH) && (cnt_q == '0) && !scl_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_LOW;
      cnt_q <= '0;
    end else if (!run_i) begin
      seg_q <= SEG_LOW;
      cnt_q <= '0;
    end else if (tick_i && !waiting) begin
      if (last) begin
        seg_q <= (seg_q == SEG_LOW) ? SEG_HIGH : SEG_LOW;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end

  assign scl_low_o = run_i && (seg_q == SEG_LOW);
  assign phase_o   = run_i ? {seg_q == SEG_HIGH, cnt_q >= mid} : 2'd0;
  assign sda_chg_o = tick_i && (seg_q == SEG_LOW)  && (cnt_q == mid);
  assign sda_smp_o = tick_i && (seg_q == SEG_HIGH) && (cnt_q == mid);

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && waiting |=> (seg_q == SEG_HIGH) && (cnt_q == '0)); // R5
  AST_SEG_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !waiting && last |=> seg_q != $past(seg_q)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < half); // R3
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int unsigned CDF_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [CDF_W+SCGD_W-1:0] div_cfg_i,
  input  logic                    scl_i,
  output logic                    tick_o,
  output logic                    scl_low_o,
  output logic [1:0]              phase_o,
  output logic                    sda_chg_o,
  output logic                    sda_smp_o
);
  localparam int unsigned CFG_W = CDF_W + SCGD_W;

  logic              run_q;
  logic [CDF_W-1:0]  cdf_q;
  logic [SCGD_W-1:0] scgd_q;
  logic              scl_s;
  logic              tick;

  // configuration captured only on the enabling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cdf_q  <= '0;
      scgd_q <= '0;
    end else begin
      run_q <= en_i;
      if (en_i && !run_q) begin
        cdf_q  <= div_cfg_i[CDF_W-1:0];
        scgd_q <= div_cfg_i[CFG_W-1:CDF_W];
      end
    end
  end

  scl_tg_prescale #(.CDF_W(CDF_W)) i_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .cdf_i  (cdf_q),
    .tick_o (tick)
  );

  scl_tg_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (scl_i),
    .q_o    (scl_s)
  );

  scl_tg_phase i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .tick_i    (tick),
    .scgd_i    (scgd_q),
    .scl_s_i   (scl_s),
    .scl_low_o (scl_low_o),
    .phase_o   (phase_o),
    .sda_chg_o (sda_chg_o),
    .sda_smp_o (sda_smp_o)
  );

  assign tick_o = tick;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) |-> $stable(cdf_q) && $stable(scgd_q)); // R9
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !scl_low_o && !tick_o && (phase_o == 2'd0)); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sda_chg_o, sda_smp_o})); // R6
endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  localparam int CDF_W = 2;
  localparam int SYNC  = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en = 1'b0;
  logic [CDF_W+5:0] cfg = '0;
  logic             hold_low = 1'b0;
  logic             scl_line;
  logic             tick, scl_low, chg, smp;
  logic [1:0]       phase;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign scl_line = ~(scl_low | hold_low);

  scl_timing_gen #(.CDF_W(CDF_W), .SYNC_STAGES(SYNC)) i_scl_timing_gen (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .div_cfg_i (cfg),
    .scl_i     (scl_line),
    .tick_o    (tick),
    .scl_low_o (scl_low),
    .phase_o   (phase),
    .sda_chg_o (chg),
    .sda_smp_o (smp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int wait_ticks(input int c, input int h);
    int n = 0;
    for (int j = 0; j * (c + 1) + c < h + SYNC; j++) n++;
    return n;
  endfunction

  task automatic start_cfg(input int c, input int s);
    en = 1'b0;
    repeat (2) @(negedge clk);
    cfg = {s[5:0], c[1:0]};
    en = 1'b1;
    @(negedge clk);
  endtask

  // entered at the first cycle of a low half; leaves at the first cycle of the next one
  task automatic measure(input int c, input int s, input int hold);
    int half = 10 + 4 * s;
    int mid  = half / 2;
    int ex   = wait_ticks(c, hold);
    int lo = 0, hi = 0, chg_at = -1, smp_at = -1, q0 = 0, ticks = 0, last_t = -1, gap_bad = 0;
    int ph_lo0, ph_hi0;
    string t = $sformatf("cdf=%0d scgd=%0d hold=%0d", c, s, hold);
    ph_lo0 = int'(phase);
    while (scl_low && lo < 5000) begin
      if (chg) begin
        chg_at = lo;
        chk(phase == 2'd1, {"R8 phase at change ", t}, int'(phase), 1);
      end
      if (phase == 2'd0) q0++;
      if (tick) begin
        if (last_t >= 0 && lo - last_t != c + 1) gap_bad++;
        last_t = lo;
        ticks++;
      end
      lo++;
      @(negedge clk);
    end
    ph_hi0 = int'(phase);
    while (!scl_low && hi < 5000) begin
      if (hold > 0) hold_low = (hi < hold);
      if (smp) begin
        smp_at = hi;
        chk(phase == 2'd3, {"R8 phase at sample ", t}, int'(phase), 3);
      end
      hi++;
      @(negedge clk);
    end
    hold_low = 1'b0;
    chk(ph_lo0 == 0, {"R8 low start phase ", t}, ph_lo0, 0);
    chk(ph_hi0 == 2, {"R8 high start phase ", t}, ph_hi0, 2);
    chk(lo == half * (c + 1), {"R3 R10 low length ", t}, lo, half * (c + 1));
    chk(ticks == half, {"R2 ticks in low ", t}, ticks, half);
    chk(gap_bad == 0, {"R2 tick spacing ", t}, gap_bad, 0);
    chk(q0 == mid * (c + 1), {"R8 first quarter ", t}, q0, mid * (c + 1));
    chk(chg_at == mid * (c + 1) + c, {"R6 change strobe ", t}, chg_at, mid * (c + 1) + c);
    chk(hi == (half + ex) * (c + 1), {"R4 R5 high length ", t}, hi, (half + ex) * (c + 1));
    chk(smp_at == (mid + ex) * (c + 1) + c, {"R7 sample strobe ", t}, smp_at, (mid + ex) * (c + 1) + c);
  endtask

  task automatic check_quiet(input string tag);
    chk(!scl_low, {"R1 scl released ", tag}, int'(scl_low), 0);
    chk(!tick, {"R1 no tick ", tag}, int'(tick), 0);
    chk(phase == 2'd0, {"R1 phase zero ", tag}, int'(phase), 0);
    chk(!chg && !smp, {"R1 no strobes ", tag}, int'({chg, smp}), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sl[7] = '{0, 1, 2, 3, 7, 31, 63};
    repeat (3) @(negedge clk);
    check_quiet("in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_quiet("after reset");

    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 7; k++) begin
        start_cfg(c, sl[k]);
        measure(c, sl[k], 0);
        measure(c, sl[k], 0);
      end
    end

    // target stretching SCL during the high half
    start_cfg(0, 0);
    measure(0, 0, 0);
    measure(0, 0, 7);
    measure(0, 0, 0);
    start_cfg(1, 2);
    measure(1, 2, 5);

    // R9: configuration change while running is ignored
    start_cfg(1, 2);
    cfg = {6'd9, 2'd3};
    measure(1, 2, 0);
    measure(1, 2, 0);
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    measure(3, 9, 0);

    // R1: disable in the middle of a high half, then restart
    start_cfg(2, 3);
    while (scl_low) @(negedge clk);
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check_quiet($sformatf("disabled cycle %0d", i));
      @(negedge clk);
    end
    en = 1'b1;
    @(negedge clk);
    measure(2, 3, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule